// File: doc/BRIEF.md
# Multiplexed Dual-Mode Host Bus Port

This block sits between a host processor and a 128-byte register space: clock, alarm and control registers at 0x00 to 0x0D, and general storage bytes at 0x0E to 0x7F. The host shares one 8-bit bus for the address and the data. An address strobe marks the address phase. The data phase is then run with one of two strobe conventions, and a strap input selects which one.

- **Motorola-style:** one line gives the direction and a data strobe gives the timing.
- **Intel-style:** separate active-low read and write strobes are used.

All host pins pass through two-flop synchronizers into a fast system clock domain. Strobe edges are detected in that domain. The block turns them into single-cycle read and write pulses on a plain register-file interface. It also produces the output enable for the bidirectional bus.

The strap is captured only while reset is held. During reset all host activity is ignored.

Top module: `mux_bus_port`

## Requirements
- R1: On a falling edge of `as_i`, `reg_addr` takes bits 6:0 of `bus_in`, whatever the level of `cs_n`. Bit 7 is dropped. At all other times `reg_addr` holds its value.
- R2: With the strap high (Motorola-style), `rw_i` = 1 marks a read and `rw_i` = 0 marks a write. A data-strobe pulse while `rw_i` is high never causes a write.
- R3: In Motorola-style, a falling edge of `ds_i` with `rw_i` low and `cs_n` low gives exactly one `reg_we` cycle. In that cycle `reg_wdata` equals the bus value present at the edge.
- R4: In Motorola-style, a rising edge of `ds_i` with `rw_i` high and `cs_n` low gives one `reg_re` cycle. From the next cycle, `bus_oe` is 1 and `bus_out` carries the `reg_rdata` value from that cycle, until the read ends.
- R5: With the strap low (Intel-style), `ds_i` is an active-low read strobe. Its falling edge with `cs_n` low gives one `reg_re` cycle. `bus_oe` and `bus_out` then follow as in R4 while `ds_i` stays low.
- R6: In Intel-style, `rw_i` is an active-low write strobe. Its rising edge with `cs_n` low gives one `reg_we` cycle, carrying the bus value present at that edge.
- R7: A data-phase strobe edge seen while `cs_n` is high produces neither `reg_we` nor `reg_re`.
- R8: `bus_oe` is 0 whenever `cs_n` is high (with no delay) or no read is active. `bus_out` is 0 whenever `bus_oe` is 0.
- R9: While `rst_n` is low, `reg_we`, `reg_re`, `bus_oe` and `bus_out` are 0, and strobe activity has no effect. `reg_addr` is 0 after reset.
- R10: The strap `mode_moto` is sampled only while `rst_n` is low. Changing it after reset does not change the strobe convention.
- R11: A strobe change made between clock edges shows up on `reg_we`/`reg_re` in the second clock cycle that follows, and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all host pins |
| rst_n | input | 1 | Active-low synchronous reset; also the strap capture window |
| mode_moto | input | 1 | Strap: 1 = Motorola-style strobes, 0 = Intel-style |
| cs_n | input | 1 | Active-low chip select for the data phase |
| as_i | input | 1 | Address strobe; its falling edge captures the address |
| ds_i | input | 1 | Data strobe (Motorola) or active-low read strobe (Intel) |
| rw_i | input | 1 | Direction line (Motorola) or active-low write strobe (Intel) |
| bus_in | input | 8 | Input side of the multiplexed address/data bus |
| bus_out | output | 8 | Read data driven toward the bus |
| bus_oe | output | 1 | Output enable for the bus drivers |
| reg_addr | output | 7 | Latched register address |
| reg_wdata | output | 8 | Write data to the register file |
| reg_we | output | 1 | Single-cycle write pulse |
| reg_re | output | 1 | Single-cycle read pulse |
| reg_rdata | input | 8 | Read data from the register file (combinational) |

## Verification
A table of write-then-read pairs covers both strobe conventions. The addresses span the first and last control registers, the first storage byte and the top of the space. Bus values of all zeros and all ones show that no bits are lost. Directed cases cover the following:
- Writes made while deselected, and accesses made during reset. These separate an ignored access from a decoded one.
- An address latched while deselected, and an address with bit 7 set.
- A mid-read deselect, which shows the output enable drops at once.
- A strap change after reset.
- A cycle-by-cycle probe of the write pulse, which pins down the two-cycle synchronizer latency.

// File: rtl/mux_bus_port.sv
module mux_bus_port #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_moto,
  input  logic          cs_n,
  input  logic          as_i,
  input  logic          ds_i,
  input  logic          rw_i,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [DW-1:0] reg_rdata
);

  // [0] first sync stage, [1] second sync stage, [2] previous value for edge detect
  logic [2:0]    as_p, ds_p, rw_p;
  logic [1:0]    cs_p;
  logic [DW-1:0] d1, d2;
  logic          mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rd_q;
  logic          oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      as_p   <= {3{as_i}};
      ds_p   <= {3{ds_i}};
      rw_p   <= {3{rw_i}};
      cs_p   <= {2{cs_n}};
      d1     <= bus_in;
      d2     <= bus_in;
      mode_q <= mode_moto;
    end else begin
      as_p <= {as_p[1:0], as_i};
      ds_p <= {ds_p[1:0], ds_i};
      rw_p <= {rw_p[1:0], rw_i};
      cs_p <= {cs_p[0], cs_n};
      d1   <= bus_in;
      d2   <= d1;
    end
  end

  wire as_fall = ~as_p[1] &  as_p[2];
  wire ds_rise =  ds_p[1] & ~ds_p[2];
  wire ds_fall = ~ds_p[1] &  ds_p[2];
  wire rw_rise =  rw_p[1] & ~rw_p[2];
  wire sel     = ~cs_p[1];

  wire wr_edge = mode_q ? (ds_fall & ~rw_p[1]) : rw_rise;
  wire rd_edge = mode_q ? (ds_rise &  rw_p[1]) : ds_fall;
  wire rd_lvl  = sel & (mode_q ? (ds_p[1] & rw_p[1]) : ~ds_p[1]);

  assign reg_we    = rst_n & sel & wr_edge;
  assign reg_re    = rst_n & sel & rd_edge;
  assign reg_wdata = d2;
  assign reg_addr  = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (as_fall) addr_q <= d2[AW-1:0];
      if (reg_re) begin
        rd_q <= reg_rdata;
        oe_q <= 1'b1;
      end else if (!rd_lvl) begin
        oe_q <= 1'b0;
      end
    end
  end

  assign bus_oe  = rst_n & oe_q & rd_lvl & ~cs_n;
  assign bus_out = bus_oe ? rd_q : '0;

  AST_ADDR_ONLY_ON_AS: assert property (@(posedge clk) disable iff (!rst_n)
    !as_fall |=> $stable(reg_addr)); // R1
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R3
  AST_RE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re); // R5
  AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(reg_re)); // R4
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n) && $past(cs_n, 2)) |-> (!reg_we && !reg_re)); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q)); // R10

  always @(posedge clk)
    if (!rst_n) AST_RESET_QUIET: assert (!reg_we && !reg_re && !bus_oe); // R9

endmodule

// File: tb/mux_bus_port_tb.sv
module mux_bus_port_tb;
  logic clk = 0, rst_n = 0, mode_moto = 1, cs_n = 1, as_i = 0, ds_i = 0, rw_i = 1;
  logic [7:0] bus_in = 0, bus_out, reg_wdata, reg_rdata;
  logic [6:0] reg_addr;
  logic bus_oe, reg_we, reg_re;
  logic [7:0] mem [128];
  int we_cnt = 0, re_cnt = 0, checks = 0, errors = 0;
  logic [6:0] last_waddr;
  logic [7:0] last_wdata;
  logic cur_mode = 1;

  always #2.5 clk = ~clk;

  mux_bus_port u_dut (.clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .cs_n(cs_n),
    .as_i(as_i), .ds_i(ds_i), .rw_i(rw_i), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_we) begin
      we_cnt <= we_cnt + 1; last_waddr <= reg_addr; last_wdata <= reg_wdata;
      mem[reg_addr] <= reg_wdata;
    end
    if (reg_re) re_cnt <= re_cnt + 1;
  end

  // {motorola, address, data}
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 8'h00, 8'h5A}, {1'b1, 8'h0D, 8'hC3}, {1'b1, 8'h0E, 8'h01}, {1'b1, 8'h7F, 8'hFF},
    {1'b0, 8'h00, 8'hA5}, {1'b0, 8'h0B, 8'h3C}, {1'b0, 8'h40, 8'h80}, {1'b0, 8'h7F, 8'h00}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic m);
    @(negedge clk);
    rst_n = 0; cur_mode = m; mode_moto = m; cs_n = 1; as_i = 0;
    rw_i = 1; ds_i = m ? 1'b0 : 1'b1;
    wait_n(3);
    rst_n = 1;
    wait_n(3);
  endtask

  task automatic latch_addr(logic [7:0] a);
    bus_in = a; as_i = 1; wait_n(3); as_i = 0; wait_n(3);
  endtask

  task automatic bus_write(logic [7:0] d, logic sel_n);
    bus_in = d; cs_n = sel_n;
    if (cur_mode) begin
      rw_i = 0; ds_i = 1; wait_n(3); ds_i = 0; wait_n(3); cs_n = 1; rw_i = 1;
    end else begin
      rw_i = 0; wait_n(3); rw_i = 1; wait_n(3); cs_n = 1;
    end
    wait_n(3);
  endtask

  task automatic bus_read(output logic [7:0] d, output logic oe);
    cs_n = 0; rw_i = 1; wait_n(3);
    ds_i = cur_mode ? 1'b1 : 1'b0;
    wait_n(4);
    d = bus_out; oe = bus_oe;
    ds_i = cur_mode ? 1'b0 : 1'b1;
    wait_n(3); cs_n = 1; wait_n(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd; logic oe; int w0, r0;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 3 + 7);

    // R9: reset state and strobes ignored during reset
    wait_n(2);
    cs_n = 0; ds_i = 1; rw_i = 0; wait_n(3); ds_i = 0; wait_n(3); cs_n = 1; rw_i = 1;
    check("R9 no write in reset", we_cnt, 0);
    check("R9 no read in reset", re_cnt, 0);
    check("R9 oe in reset", bus_oe, 0);
    check("R9 bus_out in reset", bus_out, 0);
    rst_n = 1; wait_n(3);
    check("R9 addr after reset", reg_addr, 0);

    // table of write/read pairs (R2 R3 R4 R5 R6)
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][16] != cur_mode) do_reset(VEC[v][16]);
      w0 = we_cnt; r0 = re_cnt;
      latch_addr(VEC[v][15:8]);
      bus_write(VEC[v][7:0], 1'b0);
      check(cur_mode ? "R3 one write" : "R6 one write", we_cnt - w0, 1);
      check(cur_mode ? "R2 no read on write" : "R6 no read on write", re_cnt - r0, 0);
      check(cur_mode ? "R3 write addr" : "R6 write addr", last_waddr, VEC[v][14:8]);
      check(cur_mode ? "R3 write data" : "R6 write data", last_wdata, VEC[v][7:0]);
      bus_read(rd, oe);
      check(cur_mode ? "R4 one read" : "R5 one read", re_cnt - r0, 1);
      check(cur_mode ? "R2 no write on read" : "R5 no write on read", we_cnt - w0, 1);
      check(cur_mode ? "R4 oe" : "R5 oe", oe, 1);
      check(cur_mode ? "R4 data" : "R5 data", rd, VEC[v][7:0]);
      check("R8 oe off after read", bus_oe, 0);
    end

    // R1: address latched while deselected, bit 7 dropped
    do_reset(1'b1);
    latch_addr(8'h85);
    check("R1 addr bit7 dropped, cs high", reg_addr, 7'h05);
    bus_write(8'h6E, 1'b0);
    check("R1 write lands at latched addr", last_waddr, 7'h05);

    // R7: write while deselected ignored
    w0 = we_cnt;
    latch_addr(8'h20);
    bus_write(8'hEE, 1'b1);
    check("R7 no write when deselected", we_cnt - w0, 0);
    bus_read(rd, oe);
    check("R7 location unchanged", rd, 8'(8'h20 * 3 + 7));

    // R11: write pulse two cycles after strobe edge, one cycle wide
    latch_addr(8'h30);
    bus_in = 8'h42; cs_n = 0; rw_i = 0; ds_i = 1; wait_n(3);
    ds_i = 0;
    wait_n(1); check("R11 no pulse after 1 cycle", reg_we, 0);
    wait_n(1); check("R11 pulse after 2 cycles", reg_we, 1);
    wait_n(1); check("R11 pulse one cycle wide", reg_we, 0);
    cs_n = 1; rw_i = 1; wait_n(3);

    // R8: Intel read while deselected, then drop cs mid-read
    do_reset(1'b0);
    latch_addr(8'h10);
    ds_i = 0; wait_n(5);
    check("R8 oe low with cs high", bus_oe, 0);
    check("R8 bus_out zero with cs high", bus_out, 0);
    ds_i = 1; wait_n(3);
    cs_n = 0; wait_n(3); ds_i = 0; wait_n(4);
    check("R5 oe during read", bus_oe, 1);
    cs_n = 1; #1;
    check("R8 oe drops at once on cs high", bus_oe, 0);
    ds_i = 1; wait_n(4);

    // R10: strap change after reset has no effect (still Intel)
    mode_moto = 1;
    w0 = we_cnt;
    latch_addr(8'h50);
    bus_write(8'h99, 1'b0);
    check("R10 Intel write still decoded", we_cnt - w0, 1);
    check("R10 data", last_wdata, 8'h99);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule